// File: doc/BRIEF.md
# Iterative HI/LO Multiply-Divide Unit

This block performs integer multiplication and division for a 32-bit core without occupying the main ALU. The core offers a request carrying two operands and an operation code. The unit then works through one bit per clock. When the operation completes, it writes a pair of dedicated result registers, called HI and LO. Both registers are visible on output ports at all times. The core reads them whenever it needs a result.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While an operation is in flight, `req_ready` stays low and the unit does not queue anything. A request offered during that time is simply not taken. The requester holds or withdraws it as it likes. `busy` and `done` are plain status pins.

Signed and unsigned variants use the same shift-and-add / shift-and-subtract datapath. Operands are first reduced to magnitudes, and the signs are applied again at the end. A zero divisor takes the same number of cycles as any other divide and leaves a fixed, defined result.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: After reset, and after a reset applied in mid-operation, `hi_out` and `lo_out` are zero, `busy` and `done` are low, and `req_ready` is high.
- R2: A request is accepted on a rising edge with `req_valid` and `req_ready` high. From the next cycle, `busy` is high and `req_ready` is low for 33 cycles. `done` is high for exactly one cycle, beginning at the 33rd rising edge after the accepting edge. `busy` is low in that cycle.
- R3: `req_op` encodes the operation: 2'b00 signed multiply, 2'b01 unsigned multiply, 2'b10 signed divide, 2'b11 unsigned divide.
- R4: After a multiply, LO holds bits 31:0 and HI holds bits 63:32 of the 64-bit product. For example, 0x7FFFFFFF times 4 gives HI=0x00000001, LO=0xFFFFFFFC.
- R5: After a divide, LO holds the quotient and HI holds the remainder. For example, 103 divided by 4 gives HI=0x00000003, LO=0x00000019.
- R6: A signed divide truncates the quotient toward zero, and the remainder carries the sign of the dividend. For example, -7/2 gives LO=-3 and HI=-1.
- R7: A divide with a zero divisor completes with the normal latency and gives LO=0xFFFFFFFF and HI equal to the dividend as supplied.
- R8: While `busy` is high, `hi_out` and `lo_out` keep their previous values, and a request offered then is not taken. It has no effect on the result in flight, and it starts no operation afterwards.
- R9: Results that exceed the signed range wrap silently, and no overflow indication exists. A signed divide of 0x80000000 by 0xFFFFFFFF gives LO=0x80000000, HI=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 2 | Operation code (see R3) |
| req_a | input | 32 | Multiplicand or dividend |
| req_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle pulse: HI/LO just updated |
| hi_out | output | 32 | HI register |
| lo_out | output | 32 | LO register |

## Verification
A fault in the iteration counter or the control state shows up first as a wrong latency. `done` then arrives earlier or later than 33 edges after acceptance, and the latency check catches it on that same operation. A datapath fault, such as a wrong carry, a wrong restore decision or a wrong sign correction, stays hidden until the `done` cycle, when HI/LO take a wrong value. The vector set therefore mixes sign combinations, all-ones operands and zero divisors, so that every correction path reaches the ports. Faults in the hold logic and the handshake are exposed by comparing HI/LO during busy cycles and by checking that a request offered while busy starts nothing.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_WRAP = 2'b10
  } md_state_e;
endpackage

// File: rtl/muldiv_magnitude.sv
// Converts an operand to magnitude plus sign flag; sign only honoured
// when the operation is signed.
module muldiv_magnitude #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  input  logic         use_sign,
  output logic [W-1:0] mag,
  output logic         neg
);
  always_comb begin
    neg = use_sign & val[W-1];
    mag = neg ? (~val + 1'b1) : val;
  end
endmodule

// File: rtl/muldiv_iter_core.sv
// One-bit-per-cycle engine. The {acc_hi, acc_lo} pair serves as product
// shift register for multiply and as remainder/quotient pair for divide.
module muldiv_iter_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         is_div,
  input  logic [W-1:0] ld_a,
  input  logic [W-1:0] ld_b,
  output logic [W-1:0] acc_hi,
  output logic [W-1:0] acc_lo
);
  logic [W-1:0] opnd;
  logic [W:0]   mul_sum;
  logic [W:0]   div_shift;
  logic [W:0]   div_diff;
  logic         div_ok;

  always_comb begin
    mul_sum   = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, opnd} : '0);
    div_shift = {acc_hi, acc_lo[W-1]};
    div_diff  = div_shift - {1'b0, opnd};
    div_ok    = ~div_diff[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi <= '0;
      acc_lo <= '0;
      opnd   <= '0;
    end else if (load) begin
      acc_hi <= '0;
      acc_lo <= ld_a;
      opnd   <= ld_b;
    end else if (step) begin
      if (is_div) begin
        acc_hi <= div_ok ? div_diff[W-1:0] : div_shift[W-1:0];
        acc_lo <= {acc_lo[W-2:0], div_ok};
      end else begin
        {acc_hi, acc_lo} <= {mul_sum, acc_lo[W-1:1]};
      end
    end
  end
endmodule

// File: rtl/muldiv_result_fix.sv
// Applies sign correction and the zero-divisor rule to the raw engine output.
module muldiv_result_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] acc_hi,
  input  logic [W-1:0] acc_lo,
  input  logic         op_div,
  input  logic         neg_a,
  input  logic         neg_b,
  input  logic         b_zero,
  input  logic [W-1:0] a_raw,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod_mag;
  logic [PW-1:0] prod_fix;
  logic [W-1:0]  quo_fix;
  logic [W-1:0]  rem_fix;

  always_comb begin
    prod_mag = {acc_hi, acc_lo};
    prod_fix = (neg_a ^ neg_b) ? (~prod_mag + 1'b1) : prod_mag;
    quo_fix  = (neg_a ^ neg_b) ? (~acc_lo + 1'b1) : acc_lo;
    rem_fix  = neg_a ? (~acc_hi + 1'b1) : acc_hi;
    if (!op_div) begin
      res_hi = prod_fix[PW-1:W];
      res_lo = prod_fix[W-1:0];
    end else if (b_zero) begin
      res_hi = a_raw;
      res_lo = '1;
    end else begin
      res_hi = rem_fix;
      res_lo = quo_fix;
    end
  end
endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [1:0]   req_op,
  input  logic [W-1:0] req_a,
  input  logic [W-1:0] req_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi_out,
  output logic [W-1:0] lo_out
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

  md_state_e      state;
  logic [CNT_W-1:0] iter_cnt;
  logic           accept;
  logic           req_signed;
  logic           req_div;
  logic [W-1:0]   mag_a, mag_b;
  logic           nga, ngb;
  logic           op_div, neg_a, neg_b, b_zero;
  logic [W-1:0]   a_raw;
  logic [W-1:0]   acc_hi, acc_lo;
  logic [W-1:0]   res_hi, res_lo;

  always_comb begin
    req_ready  = (state == ST_IDLE);
    busy       = (state != ST_IDLE);
    accept     = req_valid && req_ready;
    req_div    = req_op[1];
    req_signed = (md_op_e'(req_op) == OP_MUL_S) || (md_op_e'(req_op) == OP_DIV_S);
  end

  muldiv_magnitude #(.W(W)) u_mag_a (
    .val(req_a), .use_sign(req_signed), .mag(mag_a), .neg(nga)
  );
  muldiv_magnitude #(.W(W)) u_mag_b (
    .val(req_b), .use_sign(req_signed), .mag(mag_b), .neg(ngb)
  );

  muldiv_iter_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .step(state == ST_RUN), .is_div(op_div),
    .ld_a(mag_a), .ld_b(mag_b),
    .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  muldiv_result_fix #(.W(W)) u_fix (
    .acc_hi(acc_hi), .acc_lo(acc_lo), .op_div(op_div),
    .neg_a(neg_a), .neg_b(neg_b), .b_zero(b_zero), .a_raw(a_raw),
    .res_hi(res_hi), .res_lo(res_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      iter_cnt <= '0;
      op_div   <= 1'b0;
      neg_a    <= 1'b0;
      neg_b    <= 1'b0;
      b_zero   <= 1'b0;
      a_raw    <= '0;
      done     <= 1'b0;
      hi_out   <= '0;
      lo_out   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_RUN;
            iter_cnt <= '0;
            op_div   <= req_div;
            neg_a    <= nga;
            neg_b    <= ngb;
            b_zero   <= (req_b == '0);
            a_raw    <= req_a;
          end
        end
        ST_RUN: begin
          if (iter_cnt == LAST_STEP) state <= ST_WRAP;
          else iter_cnt <= iter_cnt + 1'b1;
        end
        ST_WRAP: begin
          hi_out <= res_hi;
          lo_out <= res_lo;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hilo_muldiv_checker.sv
module hilo_muldiv_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi_out,
  input logic [W-1:0] lo_out
);
  localparam int BC_W = $clog2(W + 2) + 1;
  localparam logic [BC_W-1:0] BUSY_LEN = BC_W'(W + 1);

  logic [BC_W-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_run == BUSY_LEN) && !busy);

  assert_hold_hilo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hi_out) && $stable(lo_out)));

  assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
endmodule

bind hilo_muldiv_unit hilo_muldiv_checker #(.W(W)) u_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .hi_out(hi_out), .lo_out(lo_out)
);

// File: tb/test_hilo_muldiv_unit.sv
`timescale 1ns/1ps
module test_hilo_muldiv_unit;
  localparam int NV = 12;
  // fields: op[129:128] a[127:96] b[95:64] hi[63:32] lo[31:0]
  localparam logic [129:0] VECS [NV] = '{
    {2'b11, 32'd103,        32'd4,          32'h00000003, 32'h00000019}, // R5 R3
    {2'b00, 32'h7FFFFFFF,   32'd4,          32'h00000001, 32'hFFFFFFFC}, // R4
    {2'b01, 32'hFFFFFFFF,   32'hFFFFFFFF,   32'hFFFFFFFE, 32'h00000001}, // R4 R3 unsigned
    {2'b00, 32'hFFFFFFFF,   32'hFFFFFFFF,   32'h00000000, 32'h00000001}, // R4 R3 signed
    {2'b00, 32'hFFFFFFFD,   32'd5,          32'hFFFFFFFF, 32'hFFFFFFF1}, // R4 -3*5
    {2'b10, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFF, 32'hFFFFFFFD}, // R6 -7/2
    {2'b10, 32'd7,          32'hFFFFFFFE,   32'h00000001, 32'hFFFFFFFD}, // R6 7/-2
    {2'b11, 32'hFFFFFFF9,   32'd2,          32'h00000001, 32'h7FFFFFFC}, // R5 R3 unsigned
    {2'b11, 32'd5,          32'd0,          32'h00000005, 32'hFFFFFFFF}, // R7
    {2'b10, 32'hFFFFFFF7,   32'd0,          32'hFFFFFFF7, 32'hFFFFFFFF}, // R7 signed
    {2'b10, 32'h80000000,   32'hFFFFFFFF,   32'h00000000, 32'h80000000}, // R9
    {2'b01, 32'h80000000,   32'd2,          32'h00000001, 32'h00000000}  // R4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] req_a = '0;
  logic [31:0] req_b = '0;
  logic        busy, done;
  logic [31:0] hi_out, lo_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hilo_muldiv_unit #(.W(32)) i_hilo_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_a(req_a), .req_b(req_b), .busy(busy), .done(done),
    .hi_out(hi_out), .lo_out(lo_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] eh, input logic [31:0] el);
    int lat;
    @(negedge clk);
    req_op = op; req_a = a; req_b = b; req_valid = 1'b1;
    chk(req_ready === 1'b1, "R2", "ready before request", 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1 && req_ready === 1'b0, "R2", "busy after accept",
        {busy, req_ready}, 64'b10);
    lat = 0;
    while (done !== 1'b1 && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 33, "R2", "latency to done", 64'(lat), 64'd33);
    chk(hi_out === eh, "R3 R4 R5 R6 R7 R9", "HI result", 64'(hi_out), 64'(eh));
    chk(lo_out === el, "R3 R4 R5 R6 R7 R9", "LO result", 64'(lo_out), 64'(el));
    @(negedge clk);
    chk(done === 1'b0, "R2", "done single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] ph, pl;
    bit held, blocked;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(hi_out === 0 && lo_out === 0, "R1", "HI/LO in reset", {hi_out, lo_out}, 64'd0);
    chk(busy === 0 && done === 0 && req_ready === 1, "R1", "status in reset",
        {busy, done, req_ready}, 64'b001);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_op(VECS[i][129:128], VECS[i][127:96], VECS[i][95:64],
             VECS[i][63:32], VECS[i][31:0]);

    // R8: hold during busy, request while busy ignored
    ph = hi_out; pl = lo_out;
    held = 1'b1; blocked = 1'b1;
    @(negedge clk);
    req_op = 2'b01; req_a = 32'd6; req_b = 32'd7; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_op = 2'b11; req_a = 32'd100; req_b = 32'd10; // stays offered
    while (done !== 1'b1) begin
      if (hi_out !== ph || lo_out !== pl) held = 1'b0;
      if (req_ready !== 1'b0) blocked = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(held, "R8", "HI/LO held while busy", {hi_out, lo_out}, {ph, pl});
    chk(blocked, "R8", "ready low while busy", 64'(blocked), 64'd1);
    chk(hi_out === 0 && lo_out === 42, "R8", "result unaffected by busy request",
        {hi_out, lo_out}, 64'd42);
    @(negedge clk);
    chk(busy === 1'b0, "R8", "no operation started", 64'(busy), 64'd0);
    repeat (40) @(negedge clk);
    chk(hi_out === 0 && lo_out === 42, "R8", "HI/LO unchanged afterwards",
        {hi_out, lo_out}, 64'd42);

    // R1: reset in mid-operation
    req_op = 2'b00; req_a = 32'd9; req_b = 32'd9; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(hi_out === 0 && lo_out === 0 && busy === 0 && done === 0 && req_ready === 1,
        "R1", "reset mid-operation", {hi_out, lo_out}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(2'b11, 32'd103, 32'd4, 32'h3, 32'h19); // R5 after reset

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule